// File: doc/BRIEF.md
# Integer Cluster Cohesion Score Normalizer

This block turns per-vector dot products into one integer cohesion score for a set of binary document vectors. For each vector of a set it takes two values over a valid/ready stream: the vector's dot product with the set's summation vector, and the vector's magnitude, which has been computed beforehand. The last vector of a set is marked with a flag. For each vector the block forms the term floor(K * dot / magnitude), where K is the vector dimension. It adds the terms and, once the set is complete, divides the total by the number of vectors received. No floating-point arithmetic is used anywhere.

A single restoring divider does every division and yields one quotient bit per cycle. The input stream is held off while a division runs. The score appears on the output together with a done pulse one cycle long. The running total and the vector count then return to zero, so the next set can follow straight away. A vector whose magnitude is zero contributes a zero term, still counts toward the set size, and raises a sticky error flag that only reset clears.

Top module: `cohesion_scorer`

## Requirements
- R1: After reset, out_score is 0, out_done is 0, err_zero_mag is 0 and in_ready is 1.
- R2: A vector accepted with magnitude m greater than zero and dot product d contributes the term floor(DIM_K * d / m) to its set's total.
- R3: When the set's last vector has been processed, out_score equals floor(total of terms / n), where n is the number of vectors accepted in that set.
- R4: While a division is in progress, in_ready is 0. A tuple is accepted only in a cycle where in_valid and in_ready are both 1.
- R5: A vector with magnitude 0 contributes a term of 0, still counts toward n, and sets err_zero_mag in the cycle after it is accepted.
- R6: out_done is high for exactly one cycle per set. out_score changes only in a cycle where out_done is high, and otherwise keeps its value.
- R7: After out_done, the running total and the vector count are zero, so each set's score does not depend on earlier sets.
- R8: A set of MAX_N vectors, each with the largest dot product and a magnitude of 1, produces the exact score with no overflow.
- R9: err_zero_mag stays at 1 across later sets until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input tuple present |
| in_ready | output | 1 | Block can accept a tuple |
| in_dot | input | DOT_W | Dot product of the vector with the set's summation vector |
| in_mag | input | MAG_W | Magnitude of the vector, computed beforehand |
| in_last | input | 1 | Marks the final vector of the set |
| out_score | output | ACC_W | Cohesion score of the most recent set |
| out_done | output | 1 | One-cycle pulse when out_score is updated |
| err_zero_mag | output | 1 | Sticky flag: a zero magnitude was received |

## Verification
The hardest case to reach from the ports is a set whose running total is close to the accumulator's full width. That needs MAX_N vectors in a row, each carrying the largest dot product over a magnitude of 1. The bench builds a narrow configuration so that this set can be driven and its result predicted exactly. Magnitudes of zero in the middle of a set and on its last vector are driven separately, because the last-vector case skips the term division and goes straight to the final division. The remaining stimulus covers every magnitude against a spread of dot products, plus sets of every size from 1 to MAX_N filled with values from a pseudo-random generator.

// File: rtl/cohesion_pkg.sv
package cohesion_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_TERM  = 2'd1,
    CS_KICK  = 2'd2,
    CS_FINAL = 2'd3
  } cs_state_e;

  function automatic int unsigned cs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cs_reset_sync.sv
module cs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cs_restoring_divider.sv
module cs_restoring_divider #(
  parameter int unsigned DVD_W = 39,
  parameter int unsigned DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int unsigned STEP_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0]  rem_q, rem_d;
  logic [DVD_W-1:0]  quo_q, quo_d;
  logic [DVS_W-1:0]  dvs_q, dvs_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;

  logic [DVS_W:0] rem_shift;
  logic [DVS_W:0] diff;
  logic           take;

  always_comb begin
    rem_shift = {rem_q, quo_q[DVD_W-1]};
    diff      = rem_shift - {1'b0, dvs_q};
    take      = ~diff[DVS_W];

    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    step_d = step_q;
    busy_d = busy_q;
    done_d = 1'b0;

    if (start) begin
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
      step_d = STEP_W'(DVD_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = take ? diff[DVS_W-1:0] : rem_shift[DVS_W-1:0];
      quo_d  = {quo_q[DVD_W-2:0], take};
      step_d = step_q - 1'b1;
      if (step_q == STEP_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      step_q <= step_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q)); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R4
endmodule

// File: rtl/cs_accumulator.sv
module cs_accumulator #(
  parameter int unsigned TERM_W = 28,
  parameter int unsigned ACC_W  = 39,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [TERM_W-1:0] term,
  input  logic              cnt_en,
  input  logic              clr,
  output logic [ACC_W-1:0]  acc,
  output logic [CNT_W-1:0]  cnt
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W:0]   wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc_q} + (ACC_W + 1)'(term);
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else begin
      if (add_en) acc_d = wide_sum[ACC_W-1:0];
      if (cnt_en) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign acc = acc_q;
  assign cnt = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> !wide_sum[ACC_W]); // R8
  AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr) |=> (cnt != '0)); // R8
endmodule

// File: rtl/cohesion_scorer.sv
module cohesion_scorer #(
  parameter int unsigned DIM_K = 4000,
  parameter int unsigned DOT_W = 16,
  parameter int unsigned MAG_W = 16,
  parameter int unsigned MAX_N = 1024,
  localparam int unsigned K_W    = $clog2(DIM_K + 1),
  localparam int unsigned PROD_W = DOT_W + K_W,
  localparam int unsigned CNT_W  = $clog2(MAX_N + 1),
  localparam int unsigned ACC_W  = PROD_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DOT_W-1:0] in_dot,
  input  logic [MAG_W-1:0] in_mag,
  input  logic             in_last,
  output logic [ACC_W-1:0] out_score,
  output logic             out_done,
  output logic             err_zero_mag
);
  import cohesion_pkg::*;

  localparam int unsigned DVS_W = cs_max(MAG_W, CNT_W);
  localparam logic [PROD_W-1:0] K_VAL = PROD_W'(DIM_K);

  logic rst_sync_n;

  cs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cs_state_e        state_q, state_d;
  logic             last_q, last_d;
  logic             err_q, err_d;
  logic [ACC_W-1:0] score_q, score_d;
  logic             done_q, done_d;

  logic             accept;
  logic             mag_zero;
  logic [PROD_W-1:0] product;
  logic             div_start, div_busy, div_done;
  logic [ACC_W-1:0] div_dividend, div_quo;
  logic [DVS_W-1:0] div_divisor;
  logic             acc_add, acc_cnt, acc_clr;
  logic [ACC_W-1:0] acc_val;
  logic [CNT_W-1:0] cnt_val;

  assign in_ready = (state_q == CS_IDLE);
  assign accept   = in_valid && in_ready;
  assign mag_zero = (in_mag == '0);
  assign product  = PROD_W'(in_dot) * K_VAL;

  always_comb begin
    state_d      = state_q;
    last_d       = last_q;
    err_d        = err_q;
    score_d      = score_q;
    done_d       = 1'b0;
    div_start    = 1'b0;
    div_dividend = ACC_W'(product);
    div_divisor  = DVS_W'(in_mag);
    acc_add      = 1'b0;
    acc_cnt      = 1'b0;
    acc_clr      = 1'b0;

    case (state_q)
      CS_IDLE: begin
        if (accept) begin
          acc_cnt = 1'b1;
          last_d  = in_last;
          if (mag_zero) begin
            err_d = 1'b1;
            if (in_last) state_d = CS_KICK;
          end else begin
            div_start = 1'b1;
            state_d   = CS_TERM;
          end
        end
      end
      CS_TERM: begin
        if (div_done) begin
          acc_add = 1'b1;
          state_d = last_q ? CS_KICK : CS_IDLE;
        end
      end
      CS_KICK: begin
        div_start    = 1'b1;
        div_dividend = acc_val;
        div_divisor  = DVS_W'(cnt_val);
        state_d      = CS_FINAL;
      end
      CS_FINAL: begin
        if (div_done) begin
          score_d = div_quo;
          done_d  = 1'b1;
          acc_clr = 1'b1;
          state_d = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= CS_IDLE;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      score_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
      err_q   <= err_d;
      score_q <= score_d;
      done_q  <= done_d;
    end
  end

  cs_restoring_divider #(
    .DVD_W (ACC_W),
    .DVS_W (DVS_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  cs_accumulator #(
    .TERM_W (PROD_W),
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .add_en (acc_add),
    .term   (div_quo[PROD_W-1:0]),
    .cnt_en (acc_cnt),
    .clr    (acc_clr),
    .acc    (acc_val),
    .cnt    (cnt_val)
  );

  assign out_score    = score_q;
  assign out_done     = done_q;
  assign err_zero_mag = err_q;

  AST_READY_NOT_DIVIDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |-> !div_busy); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_done |=> !out_done); // R6
  AST_SCORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_done |-> $stable(out_score)); // R6
  AST_ZERO_MAG_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_mag == '0) |=> err_zero_mag); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_zero_mag |=> err_zero_mag); // R9
  AST_CLEARED_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_done |-> (acc_val == '0 && cnt_val == '0)); // R7
  AST_FINAL_NONZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == CS_KICK) |-> (cnt_val != '0)); // R3
endmodule

// File: tb/cohesion_scorer_bench.sv
module cohesion_scorer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K     = 13;
  localparam int DW    = 8;
  localparam int MW    = 6;
  localparam int NMAX  = 16;
  localparam int AW    = (DW + $clog2(K + 1)) + $clog2(NMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_dot = '0;
  logic [MW-1:0] in_mag = '0;
  logic          in_last = 1'b0;
  logic [AW-1:0] out_score;
  logic          out_done;
  logic          err_zero_mag;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cohesion_scorer #(.DIM_K(K), .DOT_W(DW), .MAG_W(MW), .MAX_N(NMAX)) u_cohesion_scorer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dot(in_dot), .in_mag(in_mag), .in_last(in_last),
    .out_score(out_score), .out_done(out_done), .err_zero_mag(err_zero_mag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint term_of(input int d, input int m);
    return (m == 0) ? 0 : (longint'(K) * d) / m;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic push(input int d, input int m, input bit l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dot = DW'(d); in_mag = MW'(m); in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_dot = '0; in_mag = '0; in_last = 1'b0;
    if (m != 0) check("R4 ready low during division", longint'(in_ready), 0);
  endtask

  task automatic wait_score(input string req, input longint exp);
    int waited = 0;
    longint held;
    while (!out_done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check("R6 done pulse seen", longint'(out_done), 1);
    check(req, longint'(out_score), exp);
    held = longint'(out_score);
    @(negedge clk);
    check("R6 done one cycle", longint'(out_done), 0);
    check("R6 score holds", longint'(out_score), held);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int dots[5] = '{0, 1, 127, 200, 255};
    int da[NMAX];
    int ma[NMAX];
    longint sum;

    do_reset();
    // R1 reset state
    check("R1 score", longint'(out_score), 0);
    check("R1 done", longint'(out_done), 0);
    check("R1 err", longint'(err_zero_mag), 0);
    check("R1 ready", longint'(in_ready), 1);

    // R2: every nonzero magnitude against several dot products, single-vector sets
    for (int m = 1; m < (1 << MW); m++) begin
      for (int i = 0; i < 5; i++) begin
        push(dots[i], m, 1'b1);
        wait_score("R2 single term", term_of(dots[i], m));
      end
    end

    // R3 and R7: sets of every size with generated values, back to back
    for (int rep = 0; rep < 3; rep++) begin
      for (int n = 1; n <= NMAX; n++) begin
        sum = 0;
        for (int j = 0; j < n; j++) begin
          lfsr = lfsr_next(lfsr);
          da[j] = int'(lfsr[7:0]);
          lfsr = lfsr_next(lfsr);
          ma[j] = int'(lfsr[5:0] % 63) + 1;
          sum += term_of(da[j], ma[j]);
        end
        for (int j = 0; j < n; j++) push(da[j], ma[j], j == n - 1);
        wait_score("R3 R7 set score", sum / n);
      end
    end

    // R8: full-size set at the largest possible total
    for (int j = 0; j < NMAX; j++) push((1 << DW) - 1, 1, j == NMAX - 1);
    wait_score("R8 full set", term_of((1 << DW) - 1, 1));
    check("R5 err clear before zero magnitude", longint'(err_zero_mag), 0);

    // R5: zero magnitude in the middle of a set
    push(100, 0, 1'b0);
    check("R5 err set", longint'(err_zero_mag), 1);
    push(10, 5, 1'b1);
    wait_score("R5 zero term counted", (0 + term_of(10, 5)) / 2);

    // R5: zero magnitude on the last vector
    push(50, 2, 1'b0);
    push(9, 0, 1'b1);
    wait_score("R5 zero last", term_of(50, 2) / 2);

    // R9: flag survives a clean set, clears only on reset
    push(40, 3, 1'b1);
    wait_score("R9 clean set", term_of(40, 3));
    check("R9 err sticky", longint'(err_zero_mag), 1);
    do_reset();
    check("R9 err cleared by reset", longint'(err_zero_mag), 0);
    check("R1 score after reset", longint'(out_score), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule